// File: doc/BRIEF.md
# High-Side Switch Fault Controller

This block is the digital control and protection core for a set of independent high-side power switch channels (two by default). Each channel receives an on-request level and the digitised result of an overcurrent comparator that watches the voltage drop across the external switch. From these the block produces a gate-enable output and two active-low diagnostic outputs per channel. The analog parts (comparators, gate drive, charge pump, threshold networks) sit outside and appear here only as plain digital signals.

After every turn-on the channel ignores its overcurrent comparator for a blanking window, which is a run-time cycle count. During that window the drop across a switch that is still turning on is large and would otherwise look like a fault. Once the window has closed, an overcurrent latches a fault. The fault keeps the gate off until the request falls, and it keeps the fault diagnostic low until the request rises again. A second diagnostic shows the live comparator state without any latching. A global inhibit input, a supply-drop monitor with hysteresis and a deeper undervoltage trip can all switch every gate off.

Top module: `hs_fault_ctrl`

## Requirements
- R1: While reset is high and on the edge after it, every gate_en bit is 0 and every flt_n and mon_n bit is 1.
- R2: Every asynchronous input passes through two synchronising flops. A request rising with no force-off active turns gate_en on at the third rising clock edge after the change. Request low turns the gate off.
- R3: After each turn-on, overcurrent is ignored for max(blank_len,1) cycles. If overcurrent is present the whole time, gate_en stays high for exactly max(blank_len,1)+1 samples. An overcurrent pulse that ends inside the window leaves the channel on with no fault.
- R4: An overcurrent (oc_cmp bit = 1) seen after the window turns that channel's gate off. The gate stays off while the request stays high, even when the overcurrent clears.
- R5: flt_n of a faulted channel goes low and stays low after the request falls. It returns high only on the next rising edge of that request. gate_en is never high while flt_n is low.
- R6: mon_n is the inverse of the synchronised comparator: 0 when oc_cmp is 1. It is not latched and does not depend on the gate or any fault.
- R7: inhibit = 1 turns every gate off on the edge after it is synchronised, and no fault is detected while inhibited. On release with the request still high, the channel turns on again through a new blanking window.
- R8: uv_warn = 1 turns every gate off. The off state lasts until uv_ok = 1 with uv_warn = 0, so uv_warn falling alone does not turn the gates back on.
- R9: While uv_trip = 1 every gate is off and every fault latch is cleared (flt_n = 1). When the trip ends, a channel whose request is high turns on again.
- R10: Channels are independent: a fault, its release and its diagnostics on one channel do not change another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| blank_len | input | CNT_W | Blanking window length in clock cycles (0 acts as 1) |
| inhibit | input | 1 | Global off: 1 turns all gates off |
| uv_warn | input | 1 | Supply below the drop trip threshold |
| uv_ok | input | 1 | Supply above the drop release threshold |
| uv_trip | input | 1 | Supply below the undervoltage threshold |
| on_req | input | NCH | Per-channel on request, active high |
| oc_cmp | input | NCH | Per-channel overcurrent comparator, 1 = drop above limit |
| gate_en | output | NCH | Per-channel gate enable |
| flt_n | output | NCH | Per-channel latched fault diagnostic, active low |
| mon_n | output | NCH | Per-channel live comparator diagnostic, active low |

## Verification
The hardest case to reach is the exact edge of the blanking window. The comparator has to be high before the request rises, because it passes through its own synchroniser. The bench therefore raises oc_cmp first, waits for mon_n to settle, then raises the request and counts the samples during which gate_en is high. It does this for a long window, a window of one and a window of zero. The opposite case is a pulse that ends inside the window and must leave no fault. The hysteresis case is reached by dropping uv_warn while uv_ok is still low and checking that the gates stay off until uv_ok rises.

// File: rtl/hsfc_pkg.sv
package hsfc_pkg;

    localparam int HSFC_NCH   = 2;
    localparam int HSFC_CNT_W = 16;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_BLANK,
        CH_ARMED,
        CH_TRIPPED
    } ch_state_t;

    typedef enum logic {
        SUP_GOOD,
        SUP_LOW
    } sup_state_t;

    typedef struct packed {
        logic req;
        logic req_rise;
        logic oc;
    } ch_in_t;

    typedef struct packed {
        logic gate;
        logic flt_n;
        logic mon_n;
    } ch_out_t;

    function automatic logic rising(input logic now, input logic prev);
        return now & ~prev;
    endfunction

endpackage

// File: rtl/hsfc_sync.sv
module hsfc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hsfc_supply.sv
module hsfc_supply
    import hsfc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic warn_s,
    input  logic ok_s,
    output logic low
);
    sup_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SUP_GOOD;
        end else begin
            case (st)
                SUP_GOOD: if (warn_s)           st <= SUP_LOW;
                SUP_LOW:  if (ok_s && !warn_s)  st <= SUP_GOOD;
                default:                        st <= SUP_GOOD;
            endcase
        end
    end

    assign low = (st == SUP_LOW);
endmodule

// File: rtl/hsfc_channel.sv
module hsfc_channel
    import hsfc_pkg::*;
#(
    parameter int CNT_W = HSFC_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] blank_len,
    input  ch_in_t           cin,
    input  logic             force_off,
    input  logic             hold_clr,
    output ch_out_t          cout
);
    ch_state_t        st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_nxt;
    logic             blank_end;
    logic             flt_q;
    logic             mon_q;

    assign cnt_nxt   = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    assign blank_end = (cnt_nxt >= {1'b0, blank_len});

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= CH_IDLE;
            cnt   <= '0;
            flt_q <= 1'b0;
            mon_q <= 1'b1;
        end else begin
            mon_q <= ~cin.oc;
            if (hold_clr) begin
                st    <= CH_IDLE;
                cnt   <= '0;
                flt_q <= 1'b0;
            end else begin
                if (cin.req_rise) flt_q <= 1'b0;
                case (st)
                    CH_IDLE: begin
                        if (cin.req && !force_off) begin
                            st  <= CH_BLANK;
                            cnt <= '0;
                        end
                    end
                    CH_BLANK: begin
                        if (!cin.req || force_off) st <= CH_IDLE;
                        else if (blank_end)        st <= CH_ARMED;
                        else                       cnt <= cnt_nxt[CNT_W-1:0];
                    end
                    CH_ARMED: begin
                        if (!cin.req || force_off) begin
                            st <= CH_IDLE;
                        end else if (cin.oc) begin
                            st    <= CH_TRIPPED;
                            flt_q <= 1'b1;
                        end
                    end
                    CH_TRIPPED: begin
                        if (!cin.req) st <= CH_IDLE;
                    end
                    default: st <= CH_IDLE;
                endcase
            end
        end
    end

    assign cout.gate  = (st == CH_BLANK) || (st == CH_ARMED);
    assign cout.flt_n = ~flt_q;
    assign cout.mon_n = mon_q;
endmodule

// File: rtl/hs_fault_ctrl.sv
module hs_fault_ctrl
    import hsfc_pkg::*;
#(
    parameter int NCH   = HSFC_NCH,
    parameter int CNT_W = HSFC_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] blank_len,
    input  logic             inhibit,
    input  logic             uv_warn,
    input  logic             uv_ok,
    input  logic             uv_trip,
    input  logic [NCH-1:0]   on_req,
    input  logic [NCH-1:0]   oc_cmp,
    output logic [NCH-1:0]   gate_en,
    output logic [NCH-1:0]   flt_n,
    output logic [NCH-1:0]   mon_n
);
    localparam int SW = 2 * NCH + 4;

    logic [SW-1:0]  raw_in;
    logic [SW-1:0]  syn_in;
    logic           inhibit_s;
    logic           warn_s;
    logic           ok_s;
    logic           trip_s;
    logic [NCH-1:0] req_s;
    logic [NCH-1:0] oc_s;
    logic [NCH-1:0] req_d;
    logic           sup_low;
    logic           force_off;

    assign raw_in = {inhibit, uv_warn, uv_ok, uv_trip, on_req, oc_cmp};

    hsfc_sync #(.W(SW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    assign {inhibit_s, warn_s, ok_s, trip_s, req_s, oc_s} = syn_in;

    always_ff @(posedge clk) begin
        if (rst) req_d <= '0;
        else     req_d <= req_s;
    end

    hsfc_supply u_supply (
        .clk    (clk),
        .rst    (rst),
        .warn_s (warn_s),
        .ok_s   (ok_s),
        .low    (sup_low)
    );

    assign force_off = inhibit_s | sup_low | trip_s;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ch_in_t  cin;
        ch_out_t cout;

        assign cin.req      = req_s[i];
        assign cin.req_rise = rising(req_s[i], req_d[i]);
        assign cin.oc       = oc_s[i];

        hsfc_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .blank_len (blank_len),
            .cin       (cin),
            .force_off (force_off),
            .hold_clr  (trip_s),
            .cout      (cout)
        );

        assign gate_en[i] = cout.gate;
        assign flt_n[i]   = cout.flt_n;
        assign mon_n[i]   = cout.mon_n;
    end
endmodule

// File: rtl/hsfc_checker.sv
module hsfc_checker #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] gate_en,
    input logic [NCH-1:0] flt_n,
    input logic [NCH-1:0] mon_n,
    input logic [NCH-1:0] oc_cmp,
    input logic [NCH-1:0] req_s,
    input logic           force_off,
    input logic           trip_s
);
    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 7)  age <= age + 3'd1;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (gate_en == '0 && flt_n == '1 && mon_n == '1));

    a_r7_r8_forced_off: assert property (@(posedge clk) disable iff (rst)
        force_off |=> (gate_en == '0));

    a_r9_trip_clears: assert property (@(posedge clk) disable iff (rst)
        trip_s |=> (flt_n == '1));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        a_r5_no_gate_with_fault: assert property (@(posedge clk) disable iff (rst)
            gate_en[i] |-> flt_n[i]);

        a_r3_blank_holds: assert property (@(posedge clk) disable iff (rst)
            ($rose(gate_en[i]) && req_s[i] && !force_off) |=> gate_en[i]);

        a_r6_live_monitor: assert property (@(posedge clk) disable iff (rst)
            (age >= 3'd5 && $past(oc_cmp[i], 1) == oc_cmp[i] &&
             $past(oc_cmp[i], 2) == oc_cmp[i] && $past(oc_cmp[i], 3) == oc_cmp[i])
            |-> (mon_n[i] == !oc_cmp[i]));
    end
endmodule

bind hs_fault_ctrl hsfc_checker #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .gate_en   (gate_en),
    .flt_n     (flt_n),
    .mon_n     (mon_n),
    .oc_cmp    (oc_cmp),
    .req_s     (req_s),
    .force_off (force_off),
    .trip_s    (trip_s)
);

// File: tb/hs_fault_ctrl_bench.sv
module hs_fault_ctrl_bench;
    localparam int NCH   = 2;
    localparam int CNT_W = 16;
    localparam int NVEC  = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic [CNT_W-1:0] blank_len;
    logic             inhibit, uv_warn, uv_ok, uv_trip;
    logic [NCH-1:0]   on_req, oc_cmp;
    logic [NCH-1:0]   gate_en, flt_n, mon_n;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    hs_fault_ctrl #(.NCH(NCH), .CNT_W(CNT_W)) u_hs_fault_ctrl (
        .clk(clk), .rst(rst), .blank_len(blank_len), .inhibit(inhibit),
        .uv_warn(uv_warn), .uv_ok(uv_ok), .uv_trip(uv_trip),
        .on_req(on_req), .oc_cmp(oc_cmp),
        .gate_en(gate_en), .flt_n(flt_n), .mon_n(mon_n)
    );

    // {inhibit, uv_warn, uv_ok, uv_trip, req[1:0], oc[1:0], gate[1:0], flt_n[1:0], mon_n[1:0]}
    localparam logic [13:0] TBL [NVEC] = '{
        14'b0010_00_00_00_11_11,  // idle
        14'b0010_01_00_01_11_11,  // ch0 on
        14'b0010_11_00_11_11_11,  // both on
        14'b0010_11_01_10_10_10,  // ch0 fault
        14'b0010_11_00_10_10_11,  // fault holds, oc cleared
        14'b0010_10_00_10_10_11,  // req low, flag kept
        14'b0010_11_00_11_11_11,  // rising edge clears
        14'b1010_11_00_00_11_11,  // inhibit
        14'b1010_11_10_00_11_01,  // oc while inhibited: no fault
        14'b0010_11_00_11_11_11,  // release, restart
        14'b0100_11_00_00_11_11,  // supply drop
        14'b0000_11_00_00_11_11,  // warn gone, no release yet
        14'b0010_11_00_11_11_11,  // release flag
        14'b0010_11_10_01_01_01,  // ch1 fault
        14'b0011_11_00_00_11_11,  // trip clears latches
        14'b0010_11_00_11_11_11   // trip gone
    };

    string tags [NVEC];

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic count_high(input int ch, input int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (gate_en[ch]) c++;
        end
    endtask

    initial begin
        int cnt;
        tags = '{"R2", "R2", "R10", "R4", "R4", "R5", "R5", "R7",
                 "R7", "R7", "R8", "R8", "R8", "R10", "R9", "R9"};
        blank_len = 16'd20;
        inhibit = 0; uv_warn = 0; uv_ok = 1; uv_trip = 0;
        on_req = '0; oc_cmp = '0;
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "gate during reset", gate_en, 0);
        do_reset();
        chk("R1", "gate after reset", gate_en, 0);
        chk("R1", "flt_n after reset", flt_n, 3);
        chk("R1", "mon_n after reset", mon_n, 3);

        // R2 latency: third rising edge
        on_req[0] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2", "gate after 2 edges", gate_en[0], 0);
        @(negedge clk);
        chk("R2", "gate after 3 edges", gate_en[0], 1);
        on_req[0] = 1'b0;
        repeat (6) @(negedge clk);
        chk("R2", "gate off after req low", gate_en[0], 0);

        // R3 continuous overcurrent with window of 20
        oc_cmp[0] = 1'b1;
        repeat (6) @(negedge clk);
        chk("R6", "mon_n follows comparator", mon_n[0], 0);
        on_req[0] = 1'b1;
        count_high(0, 40, cnt);
        chk("R3", "on samples, len 20", cnt, 21);
        chk("R4", "gate off after fault", gate_en[0], 0);
        chk("R5", "flt_n low after fault", flt_n[0], 0);
        chk("R10", "other channel untouched", {gate_en[1], flt_n[1]}, 1);
        oc_cmp[0] = 1'b0;
        repeat (8) @(negedge clk);
        chk("R4", "gate stays off, oc cleared", gate_en[0], 0);
        on_req[0] = 1'b0;
        repeat (8) @(negedge clk);
        chk("R5", "flt_n held after req low", flt_n[0], 0);
        on_req[0] = 1'b1;
        repeat (8) @(negedge clk);
        chk("R5", "flt_n cleared on rise", flt_n[0], 1);
        on_req[0] = 1'b0;
        repeat (6) @(negedge clk);

        // R3 pulse ending inside the window
        on_req[0] = 1'b1;
        repeat (3) @(negedge clk);
        oc_cmp[0] = 1'b1;
        repeat (10) @(negedge clk);
        oc_cmp[0] = 1'b0;
        repeat (30) @(negedge clk);
        chk("R3", "gate on after masked pulse", gate_en[0], 1);
        chk("R3", "no fault after masked pulse", flt_n[0], 1);
        on_req[0] = 1'b0;
        repeat (6) @(negedge clk);

        // R3 window of 1 and 0
        for (int len = 1; len >= 0; len--) begin
            blank_len = CNT_W'(len);
            oc_cmp[0] = 1'b1;
            repeat (6) @(negedge clk);
            on_req[0] = 1'b1;
            count_high(0, 12, cnt);
            chk("R3", $sformatf("on samples, len %0d", len), cnt, 2);
            on_req[0] = 1'b0;
            oc_cmp[0] = 1'b0;
            repeat (8) @(negedge clk);
        end

        // table walk with window of 4
        blank_len = 16'd4;
        do_reset();
        for (int i = 0; i < NVEC; i++) begin
            {inhibit, uv_warn, uv_ok, uv_trip, on_req, oc_cmp} = TBL[i][13:6];
            repeat (12) @(negedge clk);
            chk(tags[i], $sformatf("vec %0d gate", i), gate_en, int'(TBL[i][5:4]));
            chk(tags[i], $sformatf("vec %0d flt_n", i), flt_n, int'(TBL[i][3:2]));
            chk("R6", $sformatf("vec %0d mon_n", i), mon_n, int'(TBL[i][1:0]));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule